// File: doc/BRIEF.md
# Soft-Mute Digital Attenuator

This block scales a stereo stream of signed 32-bit samples by a per-channel volume. Each volume is an 8-bit code in half-decibel steps. The top code passes the sample unchanged, and code zero silences the channel. A new code never takes effect in one jump. A per-channel effective code walks toward the requested code one step at a time, and the pace is set by a two-bit rate select. A soft-mute input moves both targets to silence, and releasing it walks the gain back up to the programmed levels at the same pace.

The block also watches each input channel for long runs of zero samples. A channel raises its own zero flag once its input has been exactly zero for 8192 consecutive sample strobes. A polarity input selects whether the flag is active high or active low.

Samples are taken on clock edges where the strobe is high. The scaled result appears on the output one clock later and holds until the next strobe.

Top module: `soft_mute_atten`

## Requirements
- R1: When a channel's effective code is FFh, a strobed sample appears unchanged on that channel's output.
- R2: For effective code c from 01h to FFh, the gain is G = round(2^23 * 10^(-(255-c)/40)). The output is (x*G + 2^22) >> 23, with an arithmetic shift, truncated to 32 bits.
- R3: When a channel's effective code is 00h, its output is zero for any input sample.
- R4: A shared divider, cleared by reset, counts strobes. On a strobe where the divider is at least N-1, it returns to zero and each effective code moves one step toward its target. On any other strobe it increments. N is 1, 2, 4 or 8 for rate select 0, 1, 2 or 3. An effective code changes by at most one per clock.
- R5: While soft mute is high, each channel's target is 00h. While it is low, the target is the channel's attenuation input. Both directions of the ramp use the same pace.
- R6: Reset clears the outputs, the effective codes (so the gain ramps up from silence after reset), the divider and the zero-run counters.
- R7: A channel's zero flag becomes active after the strobe that completes 8192 consecutive zero samples on that channel, and not before. Each channel is independent of the other.
- R8: A strobed nonzero sample clears that channel's zero-run count. Its flag is inactive from the next clock.
- R9: With the polarity input low, the zero flags are active high. With it high, they are active low. The input acts combinationally.
- R10: Outputs change only on a strobe edge. A strobe uses the effective code held before that edge's ramp step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one clock per sample |
| left_in | input | 32 | Left input sample, two's complement |
| right_in | input | 32 | Right input sample, two's complement |
| att_left | input | 8 | Left attenuation code (FFh unity, 00h mute) |
| att_right | input | 8 | Right attenuation code |
| ramp_sel | input | 2 | Ramp pace select: one step per 1, 2, 4 or 8 strobes |
| soft_mute | input | 1 | Ramp both channels to silence while high |
| zflag_inv | input | 1 | Invert zero-flag polarity |
| left_out | output | 32 | Scaled left sample |
| right_out | output | 32 | Scaled right sample |
| zflag_left | output | 1 | Left zero-run flag |
| zflag_right | output | 1 | Right zero-run flag |

## Verification
The assertions assume that every input is settled at the rising edge and that reset is applied before the first strobe. They place no limit on strobe spacing, and attenuation codes or the rate select may change at any time, including in the middle of a ramp. The range check on the rounded product relies on the gain never exceeding unity, which holds for every code. The stimulus drives all inputs on falling edges. It varies strobe density, rewrites codes and the pace while ramps are in flight, and toggles soft mute, so the mid-ramp reversals the assertions guard are actually reached.

// File: rtl/sma_pkg.sv
package sma_pkg;

  localparam int GAIN_FRAC = 23;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int CODE_W    = 8;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef logic [GAIN_W-1:0] gain_t;

  // Linear gain for a half-decibel code; code zero is silence.
  function automatic gain_t code_to_gain(int code);
    real lin;
    int  steps;
    if (code == 0) return '0;
    steps = NUM_CODES - 1 - code;
    lin   = 10.0 ** (-real'(steps) / 40.0);
    return gain_t'($rtoi(lin * real'(1 << GAIN_FRAC) + 0.5));
  endfunction

endpackage

// File: rtl/sma_gain_rom.sv
module sma_gain_rom
  import sma_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output gain_t             gain
);

  gain_t coef_tab [NUM_CODES];

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_entry
    localparam gain_t ENTRY = code_to_gain(i);
    assign coef_tab[i] = ENTRY;
  end

  assign gain = coef_tab[code];

endmodule

// File: rtl/sma_code_ramp.sv
module sma_code_ramp
  import sma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code_q
);

  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (step_en) begin
      if (code_q < target)      code_d = code_q + 1'b1;
      else if (code_q > target) code_d = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  // R4: effective code never moves by more than one step per clock
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |->
      (((CODE_W+1)'(code_q) == (CODE_W+1)'($past(code_q)) + 1'b1) ||
       ((CODE_W+1)'(code_q) + 1'b1 == (CODE_W+1)'($past(code_q)))));

  // R4: without a ramp tick the effective code is held
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(code_q));

endmodule

// File: rtl/sma_scaler.sv
module sma_scaler
  import sma_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] sample,
  input  gain_t               gain,
  output logic [SAMPLE_W-1:0] scaled
);

  localparam int PROD_W  = SAMPLE_W + GAIN_W + 1;
  localparam int HEAD_LO = GAIN_FRAC + SAMPLE_W - 1;
  localparam logic [PROD_W-1:0] ROUND_BIAS = PROD_W'(1) << (GAIN_FRAC - 1);
  localparam gain_t UNITY = gain_t'(1) << GAIN_FRAC;

  logic [PROD_W-1:0]   prod;
  logic [PROD_W-1:0]   biased;
  logic [SAMPLE_W-1:0] scaled_d;
  logic [PROD_W-HEAD_LO-1:0] head;
  logic                unused_bits;

  always_comb begin
    prod     = {{(GAIN_W+1){sample[SAMPLE_W-1]}}, sample} *
               {{(SAMPLE_W+1){1'b0}}, gain};
    biased   = prod + ROUND_BIAS;
    scaled_d = en ? biased[GAIN_FRAC +: SAMPLE_W] : scaled;
  end

  assign head        = biased[PROD_W-1:HEAD_LO];
  assign unused_bits = ^{biased[PROD_W-1:GAIN_FRAC+SAMPLE_W], biased[GAIN_FRAC-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scaled <= '0;
    else        scaled <= scaled_d;
  end

  // R2: the rounded product always fits the sample width
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((head == '0) || (head == '1)));

  // R1: unity gain passes the sample through
  a_r1_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gain == UNITY) |=> (scaled == $past(sample)));

  // R3: zero gain silences the channel
  a_r3_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gain == '0) |=> (scaled == '0));

  // R10: output holds between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(scaled));

endmodule

// File: rtl/sma_zero_watch.sv
module sma_zero_watch #(
  parameter int SAMPLE_W = 32,
  parameter int RUN_LEN  = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                zero_seen
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (sample != '0)       cnt_d = '0;
      else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_seen = (cnt_q == FULL);

  // R8: a nonzero strobed sample clears the flag at once
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sample != '0) |=> !zero_seen);

  // R7: the flag can only rise right after a strobed zero sample
  a_r7_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_seen) |-> $past(en && sample == '0));

endmodule

// File: rtl/soft_mute_atten.sv
module soft_mute_atten
  import sma_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int ZERO_RUN   = 8192,
  parameter int RAMP_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_stb,
  input  logic [SAMPLE_W-1:0]   left_in,
  input  logic [SAMPLE_W-1:0]   right_in,
  input  logic [CODE_W-1:0]     att_left,
  input  logic [CODE_W-1:0]     att_right,
  input  logic [RAMP_SEL_W-1:0] ramp_sel,
  input  logic                  soft_mute,
  input  logic                  zflag_inv,
  output logic [SAMPLE_W-1:0]   left_out,
  output logic [SAMPLE_W-1:0]   right_out,
  output logic                  zflag_left,
  output logic                  zflag_right
);

  localparam int NUM_CH     = 2;
  localparam int MAX_PERIOD = 1 << ((1 << RAMP_SEL_W) - 1);
  localparam int DIV_W      = (MAX_PERIOD > 1) ? $clog2(MAX_PERIOD) : 1;

  // shared ramp-pace divider
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   period;
  logic             tick;

  always_comb begin
    period = (DIV_W+1)'(1) << ramp_sel;
    tick   = ({1'b0, div_q} >= (period - 1'b1));
    div_d  = div_q;
    if (smp_stb) div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  logic [SAMPLE_W-1:0] samp_in  [NUM_CH];
  logic [SAMPLE_W-1:0] samp_out [NUM_CH];
  logic [CODE_W-1:0]   att_reg  [NUM_CH];
  logic [CODE_W-1:0]   code_tgt [NUM_CH];
  logic [CODE_W-1:0]   code_eff [NUM_CH];
  gain_t               gain     [NUM_CH];
  logic [NUM_CH-1:0]   zero_run;

  assign samp_in[0] = left_in;
  assign samp_in[1] = right_in;
  assign att_reg[0] = att_left;
  assign att_reg[1] = att_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign code_tgt[ch] = soft_mute ? '0 : att_reg[ch];

    sma_code_ramp u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (smp_stb & tick),
      .target  (code_tgt[ch]),
      .code_q  (code_eff[ch])
    );

    sma_gain_rom u_rom (
      .code (code_eff[ch]),
      .gain (gain[ch])
    );

    sma_scaler #(.SAMPLE_W(SAMPLE_W)) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (smp_stb),
      .sample (samp_in[ch]),
      .gain   (gain[ch]),
      .scaled (samp_out[ch])
    );

    sma_zero_watch #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(ZERO_RUN)) u_zero (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (smp_stb),
      .sample    (samp_in[ch]),
      .zero_seen (zero_run[ch])
    );

    // R5: under soft mute the effective code never climbs
    a_r5_mute_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_mute && smp_stb) |=> (code_eff[ch] <= $past(code_eff[ch])));
  end

  assign left_out    = samp_out[0];
  assign right_out   = samp_out[1];
  assign zflag_left  = zero_run[0] ^ zflag_inv;
  assign zflag_right = zero_run[1] ^ zflag_inv;

endmodule

// File: tb/soft_mute_atten_test.sv
module soft_mute_atten_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_stb;
  logic [31:0] left_in, right_in;
  logic [7:0]  att_left, att_right;
  logic [1:0]  ramp_sel;
  logic        soft_mute, zflag_inv;
  logic [31:0] left_out, right_out;
  logic        zflag_left, zflag_right;

  always #10 clk = ~clk;

  soft_mute_atten uut (
    .clk, .rst_n, .smp_stb, .left_in, .right_in, .att_left, .att_right,
    .ramp_sel, .soft_mute, .zflag_inv, .left_out, .right_out,
    .zflag_left, .zflag_right
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string phase = "R6";

  // behavioural reference state
  int eff_m [2];
  int cnt_m [2];
  int out_m [2];
  int div_m;

  function automatic int gain_ref(int c);
    if (c == 0) return 0;
    return $rtoi(10.0 ** (-(255.0 - real'(c)) / 40.0) * 8388608.0 + 0.5);
  endfunction

  function automatic int scale_ref(int x, int c);
    longint p;
    p = longint'(x) * longint'(gain_ref(c)) + 64'sd4194304;
    return int'(p >>> 23);
  endfunction

  function automatic int target_ref(int ch);
    if (soft_mute) return 0;
    return (ch == 0) ? int'(att_left) : int'(att_right);
  endfunction

  task automatic model_reset();
    for (int ch = 0; ch < 2; ch++) begin
      eff_m[ch] = 0; cnt_m[ch] = 0; out_m[ch] = 0;
    end
    div_m = 0;
  endtask

  task automatic model_strobe();
    int  ins [2];
    bit  stepping;
    ins[0] = int'(left_in);
    ins[1] = int'(right_in);
    stepping = (div_m >= (1 << ramp_sel) - 1);
    div_m = stepping ? 0 : div_m + 1;
    for (int ch = 0; ch < 2; ch++) begin
      out_m[ch] = scale_ref(ins[ch], eff_m[ch]);
      if (stepping) begin
        if (eff_m[ch] < target_ref(ch))      eff_m[ch]++;
        else if (eff_m[ch] > target_ref(ch)) eff_m[ch]--;
      end
      if (ins[ch] != 0)     cnt_m[ch] = 0;
      else if (cnt_m[ch] < 8192) cnt_m[ch]++;
    end
  endtask

  task automatic expect_eq(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit zl, zr;
    zl = (cnt_m[0] == 8192) ^ zflag_inv;
    zr = (cnt_m[1] == 8192) ^ zflag_inv;
    expect_eq(phase, "left_out",    longint'(int'(left_out)),  out_m[0]);
    expect_eq(phase, "right_out",   longint'(int'(right_out)), out_m[1]);
    expect_eq(phase, "zflag_left",  zflag_left,  zl);
    expect_eq(phase, "zflag_right", zflag_right, zr);
  endtask

  // inputs change on the falling edge, model steps at the rising edge
  task automatic cycle(bit stb, int l, int r);
    smp_stb  = stb;
    left_in  = l;
    right_in = r;
    @(posedge clk);
    if (stb) model_strobe();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int x;
    rst_n = 1'b0; smp_stb = 0; left_in = 0; right_in = 0;
    att_left = 8'hFF; att_right = 8'h80; ramp_sel = 0;
    soft_mute = 0; zflag_inv = 0;
    model_reset();
    @(negedge clk);
    // R6: reset state
    for (int i = 0; i < 3; i++) begin
      smp_stb = 1; left_in = 32'h7000_0000; right_in = 5;
      @(negedge clk);
      expect_eq("R6", "left_out in reset", left_out, 0);
      expect_eq("R6", "right_out in reset", right_out, 0);
      expect_eq("R6", "zflag_left in reset", zflag_left, 0);
    end
    rst_n = 1'b1;
    cycle(1, 32'h7000_0000, 5);
    expect_eq("R6", "first output after reset is silent", left_out, 0);

    // R1 / R2: ramp up to FFh and 80h
    phase = "R2";
    for (int i = 0; i < 300; i++) cycle(1, $urandom, $urandom | 1);
    phase = "R1";
    cycle(1, 32'h1234_5678, 32'h00F4_2400);
    expect_eq("R1", "unity pass-through", left_out, 32'h1234_5678);
    cycle(1, 32'h8000_0000, -1000000);
    expect_eq("R1", "unity most negative", left_out, 32'h8000_0000);
    expect_eq("R2", "code 80h scaling", longint'(int'(right_out)), scale_ref(-1000000, 8'h80));

    // R10: output holds between strobes
    phase = "R10";
    cycle(0, 32'h0BAD_0BAD, 77);
    cycle(0, 0, 0);
    expect_eq("R10", "left held without strobe", left_out, 32'h8000_0000);

    // R4: pace of eight strobes per step, divider starts at zero
    phase = "R4";
    ramp_sel = 2'd3; att_left = 8'hF0;
    for (int i = 0; i < 8; i++) cycle(1, 1000000, 3);
    expect_eq("R4", "eighth strobe still at FFh", left_out, 1000000);
    cycle(1, 1000000, 3);
    expect_eq("R4", "ninth strobe at FEh", longint'(int'(left_out)), scale_ref(1000000, 8'hFE));
    for (int i = 0; i < 140; i++) cycle(1, $urandom, $urandom);
    cycle(1, 1000000, 3);
    expect_eq("R4", "settled at F0h", longint'(int'(left_out)), scale_ref(1000000, 8'hF0));

    // R3: code 00h silences
    phase = "R3";
    ramp_sel = 2'd0; att_left = 8'h00;
    for (int i = 0; i < 260; i++) cycle(1, $urandom, $urandom | 1);
    cycle(1, 32'h8000_0000, 9);
    expect_eq("R3", "mute code output", left_out, 0);

    // R5: soft mute down and back up
    phase = "R5";
    att_left = 8'hFF; att_right = 8'hC8; ramp_sel = 2'd1;
    for (int i = 0; i < 520; i++) cycle(1, $urandom | 1, $urandom | 1);
    soft_mute = 1;
    for (int i = 0; i < 520; i++) cycle(1, $urandom | 1, $urandom | 1);
    cycle(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    expect_eq("R5", "soft mute silence left", left_out, 0);
    expect_eq("R5", "soft mute silence right", right_out, 0);
    soft_mute = 0;
    for (int i = 0; i < 520; i++) cycle(1, $urandom | 1, $urandom | 1);
    cycle(1, 32'h7FFF_FFFF, 2000000);
    expect_eq("R5", "release back to FFh", left_out, 32'h7FFF_FFFF);
    expect_eq("R5", "release back to C8h", longint'(int'(right_out)), scale_ref(2000000, 8'hC8));

    // R7: zero run on left only
    phase = "R7";
    for (int i = 0; i < 8191; i++) cycle(1, 0, 5);
    expect_eq("R7", "flag quiet after 8191 zeros", zflag_left, 0);
    cycle(1, 0, 5);
    expect_eq("R7", "flag after 8192 zeros", zflag_left, 1);
    expect_eq("R7", "other channel independent", zflag_right, 0);

    // R9: polarity acts combinationally
    phase = "R9";
    zflag_inv = 1; #1;
    expect_eq("R9", "inverted active flag", zflag_left, 0);
    expect_eq("R9", "inverted idle flag", zflag_right, 1);
    cycle(1, 0, 5);

    // R8: nonzero sample clears
    phase = "R8";
    cycle(1, 1, 5);
    expect_eq("R8", "cleared flag, inverted", zflag_left, 1);
    zflag_inv = 0; #1;
    expect_eq("R8", "cleared flag, normal", zflag_left, 0);

    // R2 / R4 / R5: mixed random traffic
    phase = "R2";
    for (int i = 0; i < 6000; i++) begin
      if (i % 97 == 0)  begin att_left = $urandom; att_right = $urandom; end
      if (i % 251 == 0) ramp_sel = $urandom;
      if (i % 613 == 0) soft_mute = $urandom;
      if (i % 1500 == 0) zflag_inv = $urandom;
      x = ($urandom % 8 == 0) ? 0 : int'($urandom);
      cycle(($urandom % 4) != 0, x, ($urandom % 8 == 0) ? 0 : int'($urandom));
    end

    finish_run();
  end

endmodule